// File: doc/BRIEF.md
# PCM Sample FIFO with Level Flags and Interrupt Status

This block holds the audio samples for one direction of a PCM serial audio port. One side pushes 16-bit samples in and the other side pops them out. In the transmit direction the register side pushes and the serial shifter pops. In the receive direction the roles are swapped. Storage is 32 entries deep. The head sample is always presented as a 17-bit readback word whose top bit says whether the sample is real.

The block reports the current fill count and four level flags: empty, almost-empty, full and almost-full. The two "almost" flags share one programmable threshold. Two error conditions are captured as sticky bits: a pop request against an empty store (starvation), and a push against a full store (overflow, where the word is lost). The four level flags and the two sticky errors form a six-bit status vector. Each bit has its own enable. A global enable gates the single pending-interrupt output. Software clears sticky bits with a one-cycle pulse and a per-bit mask.

Top module: `pcm_sample_fifo`

## Requirements
- R1: After reset the count is 0, empty and almost-empty (for threshold 4) are 1, full and almost-full are 0, both sticky error bits are 0, and the readback word is 0.
- R2: Samples leave in the order they were accepted. The readback word is {valid, sample}: bit 16 is 1 whenever the count is nonzero, and bits 15:0 then hold the oldest sample. The whole word is 0 when the store is empty.
- R3: The 6-bit count rises by one for an accepted push, falls by one for an accepted pop, is unchanged when both or neither happen, and never exceeds 32.
- R4: Empty is count==0 and full is count==32. Almost-empty is count <= threshold. Almost-full is count + threshold >= 32. The threshold is a 6-bit value from 0 to 63.
- R5: A push while the count is 32 and no pop is accepted in the same cycle is dropped. The count and the stored data do not change, and status bit 5 (overflow) is set and stays set.
- R6: A pop request while the count is 0 changes nothing in storage and sets status bit 4 (starve), which stays set.
- R7: While the enable input is low, pushes are ignored and cannot raise overflow. Pops still drain the store.
- R8: A clear pulse clears each sticky bit whose mask bit is 1 (bit 4 starve, bit 5 overflow). If the same bit's set condition occurs in that cycle, the bit stays 1.
- R9: The status vector is bit 0 empty, bit 1 almost-empty, bit 2 full, bit 3 almost-full, bit 4 starve, bit 5 overflow. The pending output is 1 exactly when the global enable is 1 and some status bit is 1 with its enable bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Accept pushes when 1 |
| push_valid | input | 1 | Push request |
| push_data | input | 16 | Sample to push |
| pop_req | input | 1 | Pop request |
| rd_word | output | 17 | {valid, head sample} |
| level_thr | input | 6 | Almost-empty / almost-full threshold |
| irq_en | input | 6 | Per-bit interrupt enables |
| irq_global_en | input | 1 | Global interrupt enable |
| clr_pulse | input | 1 | One-cycle clear strobe for sticky bits |
| clr_mask | input | 6 | Bits to clear (only 5:4 are sticky) |
| count | output | 6 | Current fill count |
| flag_empty | output | 1 | Count is 0 |
| flag_aempty | output | 1 | Count at or below threshold |
| flag_full | output | 1 | Count is 32 |
| flag_afull | output | 1 | Count plus threshold at or above 32 |
| irq_status | output | 6 | Status vector (see R9) |
| irq_pending | output | 1 | Gated interrupt request |

## Verification
Every push, pop, enable or clear presented before a rising edge is reflected on all outputs right after that edge. The count, flags, sticky bits, pending flag and readback word therefore all settle one cycle after the stimulus. Threshold, enable-mask and global-enable changes act combinationally on the flags and the pending output. The bench drives inputs on the falling edge and compares every output at the next falling edge against a queue-based model. That sample point is one rising edge after the stimulus and away from any active edge.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;
  localparam int IRQ_N = 6;
  // status vector bit positions (software decodes these)
  localparam int SRC_EMPTY  = 0;
  localparam int SRC_AEMPTY = 1;
  localparam int SRC_FULL   = 2;
  localparam int SRC_AFULL  = 3;
  localparam int SRC_STARVE = 4;
  localparam int SRC_OVF    = 5;
endpackage

// File: rtl/pcm_fifo_store.sv
module pcm_fifo_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (wr_en) wr_ptr_d = ptr_inc(wr_ptr_q);
    if (rd_en) rd_ptr_d = ptr_inc(rd_ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= wr_ptr_d;
      if (rd_en) rd_ptr_q <= rd_ptr_d;
    end
  end

  // data array carries no reset; validity comes from the count
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr_q] <= wr_data;
  end

  assign head_data = mem[rd_ptr_q];
endmodule

// File: rtl/pcm_fifo_level.sv
module pcm_fifo_level #(
  parameter int DEPTH = 32,
  parameter int LVL_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SUM_W = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic [LVL_W-1:0] thr,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             aempty,
  output logic             afull
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic [SUM_W-1:0] cnt_ext, thr_ext, cnt_plus_thr;

  assign cnt_ce = push_ok ^ pop_ok;

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_ext      = SUM_W'(cnt_q);
  assign thr_ext      = SUM_W'(thr);
  assign cnt_plus_thr = cnt_ext + thr_ext;

  assign count  = cnt_q;
  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign aempty = (cnt_ext <= thr_ext);
  assign afull  = (cnt_plus_thr >= SUM_W'(DEPTH));
endmodule

// File: rtl/pcm_fifo_irq.sv
module pcm_fifo_irq
  import pcm_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       level_src,
  input  logic             starve_evt,
  input  logic             ovf_evt,
  input  logic             clr_pulse,
  input  logic [IRQ_N-1:0] clr_mask,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             glb_en,
  output logic [IRQ_N-1:0] status,
  output logic             pending
);
  logic [1:0] stk_q, stk_d, set_v, clr_v;
  logic       stk_ce;

  assign set_v  = {ovf_evt, starve_evt};
  assign clr_v  = clr_pulse ? clr_mask[SRC_OVF:SRC_STARVE] : 2'b00;
  assign stk_ce = |set_v | |clr_v;

  // a set in the same cycle overrides the clear
  always_comb begin
    stk_d = (stk_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stk_q <= '0;
    else if (stk_ce) stk_q <= stk_d;
  end

  assign status  = {stk_q, level_src};
  assign pending = glb_en & |(status & irq_en);
endmodule

// File: rtl/pcm_sample_fifo.sv
module pcm_sample_fifo
  import pcm_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int LVL_W  = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W:0]   rd_word,
  input  logic [LVL_W-1:0]  level_thr,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              irq_global_en,
  input  logic              clr_pulse,
  input  logic [IRQ_N-1:0]  clr_mask,
  output logic [CNT_W-1:0]  count,
  output logic              flag_empty,
  output logic              flag_aempty,
  output logic              flag_full,
  output logic              flag_afull,
  output logic [IRQ_N-1:0]  irq_status,
  output logic              irq_pending
);
  logic              pop_ok, push_ok, ovf_evt, starve_evt;
  logic [DATA_W-1:0] head_data;

  // acceptance decisions
  assign pop_ok     = pop_req & ~flag_empty;
  assign push_ok    = push_valid & fifo_en & (~flag_full | pop_ok);
  assign ovf_evt    = push_valid & fifo_en & flag_full & ~pop_ok;
  assign starve_evt = pop_req & flag_empty;

  pcm_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (push_ok),
    .wr_data   (push_data),
    .rd_en     (pop_ok),
    .head_data (head_data)
  );

  pcm_fifo_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_ok(push_ok),
    .pop_ok (pop_ok),
    .thr    (level_thr),
    .count  (count),
    .empty  (flag_empty),
    .full   (flag_full),
    .aempty (flag_aempty),
    .afull  (flag_afull)
  );

  pcm_fifo_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_src ({flag_afull, flag_full, flag_aempty, flag_empty}),
    .starve_evt(starve_evt),
    .ovf_evt   (ovf_evt),
    .clr_pulse (clr_pulse),
    .clr_mask  (clr_mask),
    .irq_en    (irq_en),
    .glb_en    (irq_global_en),
    .status    (irq_status),
    .pending   (irq_pending)
  );

  assign rd_word = flag_empty ? '0 : {1'b1, head_data};
endmodule

// File: rtl/pcm_sample_fifo_chk.sv
module pcm_sample_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             push_valid,
  input logic             pop_req,
  input logic             clr_pulse,
  input logic [5:0]       clr_mask,
  input logic             irq_global_en,
  input logic [CNT_W-1:0] count,
  input logic             flag_empty,
  input logic             flag_aempty,
  input logic             flag_full,
  input logic             flag_afull,
  input logic [5:0]       irq_status,
  input logic             irq_pending
);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R3
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !pop_req) |=> $stable(count));
  // R4
  full_afull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full |-> (flag_afull && !flag_empty));
  // R4
  empty_aempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_empty |-> flag_aempty);
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && fifo_en && flag_full && !pop_req) |=> (irq_status[5] && count == CNT_W'(DEPTH)));
  // R6
  starve_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && flag_empty) |=> irq_status[4]);
  // R7
  disabled_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !pop_req) |=> $stable(count));
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[4] && !(clr_pulse && clr_mask[4])) |=> irq_status[4]);
  // R9
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_global_en |-> !irq_pending);
endmodule

bind pcm_sample_fifo pcm_sample_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .push_valid   (push_valid),
  .pop_req      (pop_req),
  .clr_pulse    (clr_pulse),
  .clr_mask     (clr_mask),
  .irq_global_en(irq_global_en),
  .count        (count),
  .flag_empty   (flag_empty),
  .flag_aempty  (flag_aempty),
  .flag_full    (flag_full),
  .flag_afull   (flag_afull),
  .irq_status   (irq_status),
  .irq_pending  (irq_pending)
);

// File: tb/tb_pcm_sample_fifo.sv
module tb_pcm_sample_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic        clk, rst_n, fifo_en, push_valid, pop_req;
  logic [15:0] push_data;
  logic [16:0] rd_word;
  logic [5:0]  level_thr, irq_en, clr_mask, count, irq_status;
  logic        irq_global_en, clr_pulse;
  logic        flag_empty, flag_aempty, flag_full, flag_afull, irq_pending;

  int n_vec = 0;
  int n_bad = 0;
  logic [15:0] mq[$];
  logic [1:0]  m_stk;

  pcm_sample_fifo dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
    .push_data(push_data), .pop_req(pop_req), .rd_word(rd_word),
    .level_thr(level_thr), .irq_en(irq_en), .irq_global_en(irq_global_en),
    .clr_pulse(clr_pulse), .clr_mask(clr_mask), .count(count),
    .flag_empty(flag_empty), .flag_aempty(flag_aempty), .flag_full(flag_full),
    .flag_afull(flag_afull), .irq_status(irq_status), .irq_pending(irq_pending)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_status();
    int sz = mq.size();
    int t  = int'(level_thr);
    return {m_stk, (sz + t >= DEPTH), (sz == DEPTH), (sz <= t), (sz == 0)};
  endfunction

  function automatic logic [16:0] exp_word();
    return (mq.size() == 0) ? 17'h0 : {1'b1, mq[0]};
  endfunction

  task automatic check_outputs();
    logic [5:0] st = exp_status();
    chk("R3", "count", 32'(count), 32'(mq.size()));
    chk("R4", "flags", {28'h0, flag_afull, flag_full, flag_aempty, flag_empty}, {26'h0, st[3:0]});
    chk("R5 R6", "sticky", 32'(irq_status[5:4]), 32'(st[5:4]));
    chk("R9", "pending", 32'(irq_pending), 32'(irq_global_en & |(st & irq_en)));
    chk("R2", "rd_word", 32'(rd_word), 32'(exp_word()));
  endtask

  // apply at falling edge, model the next rising edge, check at following falling edge
  task automatic step(input logic push, input logic [15:0] pd, input logic pop,
                      input logic en, input logic clr, input logic [5:0] mask);
    int  sz = mq.size();
    logic pop_ok, push_ok, ovf, stv;
    logic [1:0] cv;
    push_valid = push; push_data = pd; pop_req = pop;
    fifo_en = en; clr_pulse = clr; clr_mask = mask;
    pop_ok  = pop && sz > 0;
    push_ok = push && en && (sz < DEPTH || pop_ok);
    ovf     = push && en && sz == DEPTH && !pop_ok;
    stv     = pop && sz == 0;
    if (pop_ok)  void'(mq.pop_front());
    if (push_ok) mq.push_back(pd);
    cv    = clr ? mask[5:4] : 2'b00;
    m_stk = (m_stk & ~cv) | {ovf, stv};
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0; pop_req = 1'b0; clr_pulse = 1'b0;
    check_outputs();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; fifo_en = 1'b1; push_valid = 1'b0; push_data = '0; pop_req = 1'b0;
    level_thr = 6'd4; irq_en = 6'h3f; irq_global_en = 1'b1; clr_pulse = 1'b0; clr_mask = '0;
    m_stk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "count", 32'(count), 0);
    chk("R1", "flags", {28'h0, flag_afull, flag_full, flag_aempty, flag_empty}, 32'h3);
    chk("R1", "sticky", 32'(irq_status[5:4]), 0);
    chk("R1", "rd_word", 32'(rd_word), 0);

    // fill to full, then one extra push overflows (R5)
    for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 16'(i * 16'h0111 + 16'h0a05), 1'b0, 1'b1, 1'b0, '0);
    chk("R5", "count after overflow", 32'(count), DEPTH);
    chk("R5", "overflow bit", 32'(irq_status[5]), 1);
    // push+pop at full: both accepted, no new overflow
    step(1'b1, 16'hbeef, 1'b1, 1'b1, 1'b0, '0);
    // R7: disabled pushes ignored, pops still drain
    step(1'b0, '0, 1'b1, 1'b1, 1'b0, '0);
    for (int i = 0; i < 3; i++) step(1'b1, 16'h7777, 1'b0, 1'b0, 1'b0, '0);
    chk("R7", "count with enable low", 32'(count), DEPTH - 1);
    step(1'b1, 16'h7777, 1'b1, 1'b0, 1'b0, '0);
    chk("R7", "pop with enable low", 32'(count), DEPTH - 2);
    // R8: clear overflow only
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, 6'b100000);
    chk("R8", "overflow cleared", 32'(irq_status[5]), 0);
    // drain and starve (R6)
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, 1'b1, 1'b0, '0);
    chk("R6", "starve bit", 32'(irq_status[4]), 1);
    chk("R6", "count after starve", 32'(count), 0);
    // R8: set wins over simultaneous clear
    step(1'b0, '0, 1'b1, 1'b1, 1'b1, 6'b010000);
    chk("R8", "set beats clear", 32'(irq_status[4]), 1);
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, 6'b110000);
    chk("R8", "starve cleared", 32'(irq_status[4]), 0);
    // R9: global gate and per-bit enables
    irq_global_en = 1'b0;
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0);
    chk("R9", "pending gated off", 32'(irq_pending), 0);
    irq_global_en = 1'b1; irq_en = 6'b000100;
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0);
    chk("R9", "only full enabled while empty", 32'(irq_pending), 0);
    irq_en = 6'b000001;
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0);
    chk("R9", "empty enabled", 32'(irq_pending), 1);
    // R4: threshold 32 makes almost-full true when empty
    level_thr = 6'd32;
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0);
    chk("R4", "afull at thr 32", 32'(flag_afull), 1);

    // constrained random
    for (int ep = 0; ep < 20; ep++) begin
      int pp = 20 + int'($urandom % 60);
      case ($urandom % 5)
        0: level_thr = 6'd0;
        1: level_thr = 6'd4;
        2: level_thr = 6'd16;
        3: level_thr = 6'd32;
        default: level_thr = 6'd63;
      endcase
      irq_en = 6'($urandom);
      irq_global_en = 1'($urandom);
      for (int c = 0; c < 200; c++) begin
        logic pu = ($urandom % 100) < pp;
        logic po = ($urandom % 100) < 50;
        logic en = ($urandom % 10) != 0;
        logic cl = ($urandom % 16) == 0;
        step(pu, 16'($urandom), po, en, cl, 6'($urandom));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule